// File: doc/BRIEF.md
# Overlapped Pair Block Sequencer

This block turns a single continuous stream of real samples into the paired word stream that a two-input transform engine needs in order to transform two real blocks at once. Incoming samples are grouped into blocks of N. Every two consecutive blocks form a group. For each group the sequencer first emits a base pair: the earlier block goes on the real lane and the later block goes on the imaginary lane, element by element. All samples wait in a circular delay store, so a block that was the newest arrival is read back later beside its successor.

When overlap is selected, each base pair is followed by overlap pairs. An overlap pair reads the same two lanes, but its start is shifted into the blocks by half a block (50% mode) or by one, two and three quarters of a block (75% mode). Each emitted word carries the group number, the shift in quarter blocks, and a flag that marks the first element of every pair. Input is never stalled. A sample that would overwrite data still needed by the sequencer is dropped and raises a sticky overflow flag.

Top module: `ovl_pair_seq`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low until samples have been accepted.
- R2: For group g (counting from 0, input samples numbered from 0), the base pair has `out_phase` = 0. Its element i carries sample 2gN+i on `out_re` and sample 2gN+N+i on `out_im`, for i = 0..N-1, emitted in increasing i.
- R3: With `mode` code 1 (half overlap), the base pair of a group is followed by one overlap pair with `out_phase` = 2. Element i of that pair carries sample 2gN+N/2+i on the real lane and 2gN+3N/2+i on the imaginary lane.
- R4: With `mode` code 2 (quarter overlap), the base pair is followed by three overlap pairs with `out_phase` 1, 2 and 3, in that order. The pair with phase p starts its real lane at sample 2gN+pN/4 and its imaginary lane at sample 2gN+N+pN/4.
- R5: With `mode` code 0, and also with the unused code 3, only base pairs are emitted (`out_phase` stays 0).
- R6: `out_sob` is high on the first element of every emitted pair, base and overlap alike, and low on every other valid element.
- R7: An element is emitted in the cycle after the clock edge at which the last input sample it carries was accepted, unless earlier elements are still queued. Elements leave in order, one per cycle at most, with no gap while their data is present.
- R8: `out_group` is the group number modulo 2^TAG_W. It is constant within a pair and increases by one from each group's base pair to the next.
- R9: An input sample that arrives while the store holds 4N samples not yet released by the sequencer is dropped, and `overflow` goes high and stays high until reset.
- R10: The overlap mode of a group is taken from `mode` at the cycle the group's first element is emitted. A change of `mode` later in the group has no effect on that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | W | Real input sample |
| mode | input | 2 | Overlap select: 0 none, 1 half, 2 quarter, 3 treated as none |
| out_valid | output | 1 | Output element present |
| out_re | output | W | Real-lane sample (earlier block) |
| out_im | output | W | Imaginary-lane sample (later block) |
| out_sob | output | 1 | First element of a pair |
| out_phase | output | 2 | Start shift of the pair in quarter blocks |
| out_group | output | TAG_W | Group number of the pair |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench aims at the points where a sequencer of this kind tends to slip. One is the offset arithmetic of overlap pairs, where a wrong quarter step or a lane swap would put the wrong sample positions on a lane. Another is the order and count of overlap pairs in each mode; a design that ignored code 3 or stepped the phase wrongly would emit extra or missing pairs. Sparse input checks the exact cycle an element becomes ready: a readiness test off by one would emit data before it is stored, or hold it back a cycle. A mid-group mode change and a sustained quarter-overlap flood check that the mode is latched once per group and that a full store drops the sample rather than overwriting live data.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;

  typedef enum logic [1:0] {
    OVL_NONE    = 2'd0,
    OVL_HALF    = 2'd1,
    OVL_QUARTER = 2'd2,
    OVL_RSVD    = 2'd3
  } ovl_mode_e;

  // advance of the start point between pairs of one group, in quarter blocks
  function automatic logic [2:0] quarter_step(input ovl_mode_e m);
    case (m)
      OVL_HALF:    return 3'd2;
      OVL_QUARTER: return 3'd1;
      default:     return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ovl_lane_mem.sv
`timescale 1ns/1ps
module ovl_lane_mem #(
  parameter int W  = 12,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ovl_wrctl.sv
`timescale 1ns/1ps
module ovl_wrctl #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             we,
  output logic             overflow
);
  logic [CNT_W-1:0] occ;
  logic             full;

  assign occ  = wr_cnt - base;
  assign full = (occ == CNT_W'(DEPTH));
  assign we   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt   <= '0;
      overflow <= 1'b0;
    end else begin
      if (we) wr_cnt <= wr_cnt + 1'b1;
      if (in_valid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ovl_rdseq.sv
`timescale 1ns/1ps
module ovl_rdseq
  import ovl_pkg::*;
#(
  parameter int N     = 16,
  parameter int TAG_W = 8,
  parameter int CNT_W = 8,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wr_cnt,
  input  ovl_mode_e        mode_in,
  output logic [CNT_W-1:0] base,
  output logic             ren,
  output logic [AW-1:0]    raddr_re,
  output logic [AW-1:0]    raddr_im,
  output logic             out_valid,
  output logic             out_sob,
  output logic [1:0]       out_phase,
  output logic [TAG_W-1:0] out_group
);
  localparam int LOG_N = $clog2(N);

  logic [1:0]       q;
  logic [LOG_N-1:0] idx;
  ovl_mode_e        mode_q;
  logic [TAG_W-1:0] group;

  ovl_mode_e        eff_mode;
  logic             first_elem;
  logic             last_elem;
  logic [CNT_W-1:0] off;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] avail;
  logic [2:0]       nq;

  assign first_elem = (q == 2'd0) && (idx == '0);
  assign last_elem  = (idx == LOG_N'(N - 1));
  assign eff_mode   = first_elem ? mode_in : mode_q;
  assign off        = CNT_W'(q) << (LOG_N - 2);
  assign need       = CNT_W'(N) + off + CNT_W'(idx);
  assign avail      = wr_cnt - base;
  assign ren        = (avail > need);
  assign nq         = {1'b0, q} + quarter_step(eff_mode);
  assign raddr_re   = AW'(base + off + CNT_W'(idx));
  assign raddr_im   = raddr_re + AW'(N);

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      q         <= '0;
      idx       <= '0;
      mode_q    <= OVL_NONE;
      group     <= '0;
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_phase <= '0;
      out_group <= '0;
    end else begin
      out_valid <= ren;
      if (ren) begin
        out_sob   <= (idx == '0);
        out_phase <= q;
        out_group <= group;
        if (first_elem) mode_q <= mode_in;
        if (last_elem) begin
          idx <= '0;
          if (nq[2]) begin
            q     <= '0;
            base  <= base + CNT_W'(2 * N);
            group <= group + 1'b1;
          end else begin
            q <= nq[1:0];
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ovl_pair_seq.sv
`timescale 1ns/1ps
module ovl_pair_seq
  import ovl_pkg::*;
#(
  parameter int N     = 16,
  parameter int W     = 12,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  input  logic [1:0]       mode,
  output logic             out_valid,
  output logic [W-1:0]     out_re,
  output logic [W-1:0]     out_im,
  output logic             out_sob,
  output logic [1:0]       out_phase,
  output logic [TAG_W-1:0] out_group,
  output logic             overflow
);
  localparam int LOG_N = $clog2(N);
  localparam int AW    = LOG_N + 2;
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = AW + 2;

  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] base;
  logic             we;
  logic             ren;
  logic [AW-1:0]    raddr [2];
  logic [W-1:0]     rdata [2];

  ovl_wrctl #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base),
    .wr_cnt(wr_cnt), .we(we), .overflow(overflow)
  );

  ovl_rdseq #(.N(N), .TAG_W(TAG_W), .CNT_W(CNT_W), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .mode_in(ovl_mode_e'(mode)),
    .base(base), .ren(ren), .raddr_re(raddr[0]), .raddr_im(raddr[1]),
    .out_valid(out_valid), .out_sob(out_sob), .out_phase(out_phase),
    .out_group(out_group)
  );

  // lane 0 feeds the real output, lane 1 the imaginary output
  for (genvar l = 0; l < 2; l++) begin : g_lane
    ovl_lane_mem #(.W(W), .AW(AW)) u_mem (
      .clk(clk), .we(we), .waddr(wr_cnt[AW-1:0]), .wdata(in_data),
      .re(ren), .raddr(raddr[l]), .rdata(rdata[l])
    );
  end

  assign out_re = rdata[0];
  assign out_im = rdata[1];
endmodule

// File: rtl/ovl_pair_seq_chk.sv
`timescale 1ns/1ps
module ovl_pair_seq_chk #(
  parameter int N     = 16,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_sob,
  input logic [1:0]       out_phase,
  input logic [TAG_W-1:0] out_group,
  input logic             overflow
);
  localparam int LOG_N = $clog2(N);

  logic [LOG_N-1:0] elem_cnt;
  logic [TAG_W-1:0] prev_group;
  logic [1:0]       last_phase;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      elem_cnt   <= '0;
      prev_group <= '0;
      last_phase <= '0;
      seen       <= 1'b0;
    end else if (out_valid) begin
      elem_cnt <= elem_cnt + 1'b1;
      if (out_sob) begin
        prev_group <= out_group;
        last_phase <= out_phase;
        seen       <= 1'b1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !overflow));

  assert_sob_first_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sob == (elem_cnt == '0)));

  assert_pair_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sob) |-> ($stable(out_phase) && $stable(out_group)));

  assert_group_step_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sob && out_phase == 2'd0 && seen) |-> (out_group == prev_group + 1'b1));

  assert_overlap_order_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sob && out_phase != 2'd0) |->
      (seen && out_group == prev_group && out_phase > last_phase));

  assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind ovl_pair_seq ovl_pair_seq_chk #(.N(N), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_sob(out_sob),
  .out_phase(out_phase), .out_group(out_group), .overflow(overflow)
);

// File: tb/ovl_pair_seq_test.sv
`timescale 1ns/1ps
module ovl_pair_seq_test;
  localparam int N     = 16;
  localparam int W     = 12;
  localparam int TAG_W = 8;
  localparam int DEPTH = 4 * N;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [W-1:0]     in_data = '0;
  logic [1:0]       mode = 2'd0;
  logic             out_valid;
  logic [W-1:0]     out_re;
  logic [W-1:0]     out_im;
  logic             out_sob;
  logic [1:0]       out_phase;
  logic [TAG_W-1:0] out_group;
  logic             overflow;

  always #4 clk = ~clk;

  ovl_pair_seq #(.N(N), .W(W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_sob(out_sob),
    .out_phase(out_phase), .out_group(out_group), .overflow(overflow)
  );

  int    checks = 0;
  int    fails  = 0;
  int    sample_no = 0;
  bit    done = 1'b0;
  string seg = "R1";

  // behavioural reference: every accepted sample kept in arrival order
  int hist[$];
  int m_wr, m_base, m_q, m_i, m_mode, m_group;
  bit m_ovf;
  bit e_valid, e_sob;
  int e_re, e_im, e_phase, e_group;

  always @(posedge clk) begin
    int need, eff, stp, base_old, off;
    if (rst) begin
      hist.delete();
      m_wr = 0; m_base = 0; m_q = 0; m_i = 0; m_mode = 0; m_group = 0;
      m_ovf = 1'b0; e_valid = 1'b0;
    end else begin
      base_old = m_base;
      eff  = (m_q == 0 && m_i == 0) ? int'(mode) : m_mode;
      off  = m_q * (N / 4);
      need = N + off + m_i;
      if (m_wr - m_base > need) begin
        e_valid = 1'b1;
        e_re    = hist[m_base + off + m_i];
        e_im    = hist[m_base + N + off + m_i];
        e_sob   = (m_i == 0);
        e_phase = m_q;
        e_group = m_group;
        if (m_q == 0 && m_i == 0) m_mode = eff;
        if (m_i == N - 1) begin
          m_i = 0;
          stp = (eff == 1) ? 2 : (eff == 2) ? 1 : 4;
          if (m_q + stp >= 4) begin
            m_q = 0;
            m_base += 2 * N;
            m_group = (m_group + 1) % (1 << TAG_W);
          end else begin
            m_q += stp;
          end
        end else begin
          m_i++;
        end
      end else begin
        e_valid = 1'b0;
      end
      if (in_valid) begin
        if (m_wr - base_old == DEPTH) m_ovf = 1'b1;
        else begin
          hist.push_back(int'(in_data));
          m_wr++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == e_valid, (seg == "R1") ? "R7" : seg, "out_valid",
            int'(out_valid), int'(e_valid));
      if (out_valid && e_valid) begin
        check(int'(out_re) == e_re, seg, "out_re", int'(out_re), e_re);
        check(int'(out_im) == e_im, seg, "out_im", int'(out_im), e_im);
        check(out_sob == e_sob, "R6", "out_sob", int'(out_sob), int'(e_sob));
        check(int'(out_phase) == e_phase, seg, "out_phase", int'(out_phase), e_phase);
        check(int'(out_group) == e_group, "R8", "out_group", int'(out_group), e_group);
        if (seg == "R5")
          check(out_phase == 2'd0, "R5", "phase in no-overlap mode", int'(out_phase), 0);
      end
      check(overflow == m_ovf, "R9", "overflow", int'(overflow), int'(m_ovf));
    end
  end

  task automatic feed(input int count, input int gap);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(sample_no * 29 + 7);
      sample_no++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);
    idle(3);

    seg = "R2"; mode = 2'd0;  feed(4 * N, 0); idle(3 * N);
    seg = "R5"; mode = 2'd3;  feed(4 * N, 0); idle(3 * N);
    seg = "R3"; mode = 2'd1;  feed(4 * N, 0); idle(3 * N);
    seg = "R7"; mode = 2'd1;  feed(2 * N, 2); idle(3 * N);
    seg = "R4"; mode = 2'd2;  feed(4 * N, 2); idle(6 * N);
    seg = "R10"; mode = 2'd1; feed(N + N / 2, 0);
    mode = 2'd0;              feed(N / 2, 0);
    mode = 2'd2;              feed(N / 2, 0); mode = 2'd0; feed(N + N / 2, 0);
    idle(3 * N);
    seg = "R9"; mode = 2'd2;  feed(8 * N, 0); idle(10 * N);
    check(overflow == 1'b1, "R9", "overflow after quarter-overlap flood", int'(overflow), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule